// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block steps through horizontal microcode for a small multi-cycle processor. The control store is cut into slots of 16 words each, one slot per instruction, and the slot number is the value held in a small opcode register. A step counter walks through the current slot. The micro-address is the slot number times 16 plus the step count. The 32-bit word at that address goes out on a control bus. It is also split into strobes and select fields for the register file, program counter, ALU, memory port, instruction register, immediate generator and memory byte latch.

Slot 0 holds the fetch routine. When the current word has its opcode-load strobe set, the next clock loads the opcode register from the datapath and clears the step counter. A routine therefore finishes by loading zero, which sends control back to fetch. Every other programmed routine ends with the same two-step tail, which adds 4 to the program counter and clears the opcode. The store contents come from a small table in the package. Words that the table does not program read as zero.

The sequencer has two actions. `ACT_STEP` advances the step counter inside the current slot. `ACT_LOAD` installs a new slot from `ir_data` and restarts at step 0. `ACT_RESET` is a third action that takes priority over both and returns to the fetch entry. The slots are named `SLOT_FETCH` (0), `SLOT_LDUP` (1, load-upper) and `SLOT_ADDR` (2, register add).

Top module: `useq_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the opcode register and the step counter, so `upc_addr` is 0 after that edge.
- R2: `upc_addr` equals opcode*16 + step. While the current word has bit 21 clear, each clock adds one to the step, wrapping from 15 to 0, and the slot does not change.
- R3: When the current word has bit 21 (opcode load) set, the next clock loads `ir_data` into the opcode register and clears the step. Loading 0 returns `upc_addr` to 0.
- R4: `ctrl_word` is the store word at `upc_addr` in the same cycle, and its bit 0 is always 0.
- R5: The fetch slot holds these words, each given as a set of bits or fields, with everything not listed at zero. Step 0: bits 6 and 19. Steps 1 to 4: bits 17, 18 and 26, with byte-latch select (bits 29:27) set to 3, 2, 1 and 0 in that order; steps 1 to 3 also set bit 20. Step 5: bits 15 and 21.
- R6: The shared tail is two words. The first sets bits 6 and 8. The second sets bits 10, 21 and pc-write condition (bits 5:3) = 1 ("always"), with ALU select 0 (add 4).
- R7: Slot 1, step 0 sets bits 25 and 1, immediate select (bits 24:22) = 3, and register select (bits 31:30) = 2. Steps 1 and 2 hold the tail. The immediate codes are I=0, S=1, B=2, U=3, J=4. The register select codes are rs1=0, rs2=1, rsd=2, r0=3.
- R8: Slot 2 holds five words. Step 0 sets bits 2 and 8 with select rs1. Step 1 sets bits 2 and 9 with select rs2. Step 2 sets bits 10 and 1, ALU select (bits 14:11) = 1 (add) and select rsd. Steps 3 and 4 hold the tail.
- R9: Every store word not listed in R5 to R8 is zero.
- R10: Each decoded port equals its field of `ctrl_word`, at the bit positions listed in the port table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ir_data | input | SLOT_BITS (4) | Value loaded into the opcode register on an opcode-load step |
| upc_addr | output | SLOT_BITS+STEP_BITS (8) | Current micro-address {slot, step} |
| ctrl_word | output | 32 | Current control word |
| reg_wr | output | 1 | Register file write, bit 1 |
| reg_rd | output | 1 | Register file read, bit 2 |
| pc_wr_cond | output | 3 | PC write condition, bits 5:3 |
| pc_rd | output | 1 | PC onto bus, bit 6 |
| cmp_latch | output | 1 | Latch compare result, bit 7 |
| alu_a_wr | output | 1 | Load ALU operand A, bit 8 |
| alu_b_wr | output | 1 | Load ALU operand B, bit 9 |
| alu_o_rd | output | 1 | ALU result onto bus, bit 10 |
| alu_op | output | 4 | ALU operation, bits 14:11 |
| mdata_rd | output | 1 | Memory data register onto bus, bit 15 |
| mdata_wr | output | 1 | Load memory data register, bit 16 |
| mem_en | output | 1 | Memory access enable, bit 17 |
| mem_rw | output | 1 | Memory read (1) or write (0), bit 18 |
| maddr_wr | output | 1 | Load memory address register, bit 19 |
| maddr_inc | output | 1 | Increment memory address, bit 20 |
| ir_wr | output | 1 | Opcode register load, bit 21 |
| imm_sel | output | 3 | Immediate format, bits 24:22 |
| imm_en | output | 1 | Immediate onto bus, bit 25 |
| blatch_en | output | 1 | Byte latch enable, bit 26 |
| blatch_sel | output | 3 | Byte latch lane and direction, bits 29:27 |
| reg_sel | output | 2 | Register index source, bits 31:30 |

## Verification
The step counter wraps only in a slot whose words never set the opcode-load bit. Every programmed routine leaves its slot well before step 15, so normal instruction flow never reaches the wrap. The stimulus therefore loads an opcode that selects an unprogrammed slot and holds it for more than 16 cycles. This covers the wrap and also the all-zero words of R9. The random phase also feeds such opcodes, and it escapes them with a reset after a bounded wait.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int CW_BITS = 32;

    localparam int B_REG_WR  = 1;
    localparam int B_REG_RD  = 2;
    localparam int B_PCW_LO  = 3;
    localparam int B_PC_RD   = 6;
    localparam int B_CMP     = 7;
    localparam int B_ALU_A   = 8;
    localparam int B_ALU_B   = 9;
    localparam int B_ALU_O   = 10;
    localparam int B_ALU_LO  = 11;
    localparam int B_MD_RD   = 15;
    localparam int B_MD_WR   = 16;
    localparam int B_MEM_EN  = 17;
    localparam int B_MEM_RW  = 18;
    localparam int B_MA_WR   = 19;
    localparam int B_MA_INC  = 20;
    localparam int B_IR_WR   = 21;
    localparam int B_IMM_LO  = 22;
    localparam int B_IMM_EN  = 25;
    localparam int B_BL_EN   = 26;
    localparam int B_BL_LO   = 27;
    localparam int B_RSEL_LO = 30;

    typedef enum logic [2:0] {IMM_I = 3'd0, IMM_S = 3'd1, IMM_B = 3'd2, IMM_U = 3'd3, IMM_J = 3'd4} imm_kind_e;
    typedef enum logic [1:0] {RS_SRC1 = 2'd0, RS_SRC2 = 2'd1, RS_DEST = 2'd2, RS_ZERO = 2'd3} rsel_e;
    typedef enum logic [2:0] {PCW_NEVER = 3'd0, PCW_ALWAYS = 3'd1} pcw_e;
    typedef enum logic [3:0] {ALU_ADD4 = 4'd0, ALU_ADD = 4'd1} alu_e;
    typedef enum int {SLOT_FETCH = 0, SLOT_LDUP = 1, SLOT_ADDR = 2} slot_e;

    typedef struct packed {
        logic [1:0] reg_sel;
        logic [2:0] blatch_sel;
        logic       blatch_en;
        logic       imm_en;
        logic [2:0] imm_sel;
        logic       ir_wr;
        logic       maddr_inc;
        logic       maddr_wr;
        logic       mem_rw;
        logic       mem_en;
        logic       mdata_wr;
        logic       mdata_rd;
        logic [3:0] alu_op;
        logic       alu_o_rd;
        logic       alu_b_wr;
        logic       alu_a_wr;
        logic       cmp_latch;
        logic       pc_rd;
        logic [2:0] pc_wr_cond;
        logic       reg_rd;
        logic       reg_wr;
    } ctrl_t;

    function automatic logic [CW_BITS-1:0] fbit(int pos);
        return CW_BITS'(1) << pos;
    endfunction

    function automatic logic [CW_BITS-1:0] ffld(int lo, int val);
        return CW_BITS'(val) << lo;
    endfunction

    function automatic logic [CW_BITS-1:0] tail_word(int idx);
        if (idx == 0)
            return fbit(B_PC_RD) | fbit(B_ALU_A);
        return fbit(B_ALU_O) | fbit(B_IR_WR) | ffld(B_PCW_LO, int'(PCW_ALWAYS))
             | ffld(B_ALU_LO, int'(ALU_ADD4));
    endfunction

    function automatic logic [CW_BITS-1:0] fetch_word(int step);
        logic [CW_BITS-1:0] w;
        w = '0;
        if (step == 0)
            w = fbit(B_PC_RD) | fbit(B_MA_WR);
        else if (step >= 1 && step <= 4) begin
            w = fbit(B_MEM_EN) | fbit(B_MEM_RW) | fbit(B_BL_EN) | ffld(B_BL_LO, 4 - step);
            if (step < 4)
                w = w | fbit(B_MA_INC);
        end else if (step == 5)
            w = fbit(B_MD_RD) | fbit(B_IR_WR);
        return w;
    endfunction

    function automatic logic [CW_BITS-1:0] store_word(int slot, int step);
        logic [CW_BITS-1:0] w;
        w = '0;
        case (slot)
            SLOT_FETCH: w = fetch_word(step);
            SLOT_LDUP: begin
                if (step == 0)
                    w = fbit(B_IMM_EN) | fbit(B_REG_WR) | ffld(B_IMM_LO, int'(IMM_U))
                      | ffld(B_RSEL_LO, int'(RS_DEST));
                else if (step == 1 || step == 2)
                    w = tail_word(step - 1);
            end
            SLOT_ADDR: begin
                if (step == 0)
                    w = fbit(B_REG_RD) | fbit(B_ALU_A) | ffld(B_RSEL_LO, int'(RS_SRC1));
                else if (step == 1)
                    w = fbit(B_REG_RD) | fbit(B_ALU_B) | ffld(B_RSEL_LO, int'(RS_SRC2));
                else if (step == 2)
                    w = fbit(B_ALU_O) | fbit(B_REG_WR) | ffld(B_ALU_LO, int'(ALU_ADD))
                      | ffld(B_RSEL_LO, int'(RS_DEST));
                else if (step == 3 || step == 4)
                    w = tail_word(step - 3);
            end
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/useq_upc.sv
module useq_upc #(
    parameter int SLOT_BITS = 4,
    parameter int STEP_BITS = 4,
    localparam int ADDR_W = SLOT_BITS + STEP_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [SLOT_BITS-1:0] load_slot,
    output logic [ADDR_W-1:0]    upc
);

    typedef enum logic [1:0] {ACT_STEP, ACT_LOAD, ACT_RESET} upc_act_e;

    upc_act_e             act;
    logic [SLOT_BITS-1:0] slot_q, slot_d;
    logic [STEP_BITS-1:0] step_q, step_d;

    always_comb begin
        if (rst)
            act = ACT_RESET;
        else if (load)
            act = ACT_LOAD;
        else
            act = ACT_STEP;
    end

    always_comb begin
        slot_d = slot_q;
        step_d = step_q;
        unique case (act)
            ACT_RESET: begin
                slot_d = '0;
                step_d = '0;
            end
            ACT_LOAD: begin
                slot_d = load_slot;
                step_d = '0;
            end
            ACT_STEP: step_d = step_q + 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        slot_q <= slot_d;
        step_q <= step_d;
    end

    assign upc = {slot_q, step_q};

endmodule

// File: rtl/useq_store.sv
module useq_store #(
    parameter int SLOT_BITS = 4,
    parameter int STEP_BITS = 4,
    localparam int ADDR_W = SLOT_BITS + STEP_BITS,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int SLOT_WORDS = 1 << STEP_BITS
) (
    input  logic [ADDR_W-1:0]                addr,
    output logic [useq_pkg::CW_BITS-1:0]     word
);

    logic [useq_pkg::CW_BITS-1:0] rom [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_rom
        assign rom[a] = useq_pkg::store_word(a / SLOT_WORDS, a % SLOT_WORDS);
    end

    assign word = rom[addr];

endmodule

// File: rtl/useq_decode.sv
module useq_decode
    import useq_pkg::*;
(
    input  logic [CW_BITS-1:1] word,
    output ctrl_t              ctl
);

    always_comb begin
        ctl.reg_wr     = word[B_REG_WR];
        ctl.reg_rd     = word[B_REG_RD];
        ctl.pc_wr_cond = word[B_PCW_LO +: 3];
        ctl.pc_rd      = word[B_PC_RD];
        ctl.cmp_latch  = word[B_CMP];
        ctl.alu_a_wr   = word[B_ALU_A];
        ctl.alu_b_wr   = word[B_ALU_B];
        ctl.alu_o_rd   = word[B_ALU_O];
        ctl.alu_op     = word[B_ALU_LO +: 4];
        ctl.mdata_rd   = word[B_MD_RD];
        ctl.mdata_wr   = word[B_MD_WR];
        ctl.mem_en     = word[B_MEM_EN];
        ctl.mem_rw     = word[B_MEM_RW];
        ctl.maddr_wr   = word[B_MA_WR];
        ctl.maddr_inc  = word[B_MA_INC];
        ctl.ir_wr      = word[B_IR_WR];
        ctl.imm_sel    = word[B_IMM_LO +: 3];
        ctl.imm_en     = word[B_IMM_EN];
        ctl.blatch_en  = word[B_BL_EN];
        ctl.blatch_sel = word[B_BL_LO +: 3];
        ctl.reg_sel    = word[B_RSEL_LO +: 2];
    end

endmodule

// File: rtl/useq_top.sv
module useq_top #(
    parameter int SLOT_BITS = 4,
    parameter int STEP_BITS = 4,
    localparam int ADDR_W = SLOT_BITS + STEP_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SLOT_BITS-1:0] ir_data,
    output logic [ADDR_W-1:0]    upc_addr,
    output logic [31:0]          ctrl_word,
    output logic                 reg_wr,
    output logic                 reg_rd,
    output logic [2:0]           pc_wr_cond,
    output logic                 pc_rd,
    output logic                 cmp_latch,
    output logic                 alu_a_wr,
    output logic                 alu_b_wr,
    output logic                 alu_o_rd,
    output logic [3:0]           alu_op,
    output logic                 mdata_rd,
    output logic                 mdata_wr,
    output logic                 mem_en,
    output logic                 mem_rw,
    output logic                 maddr_wr,
    output logic                 maddr_inc,
    output logic                 ir_wr,
    output logic [2:0]           imm_sel,
    output logic                 imm_en,
    output logic                 blatch_en,
    output logic [2:0]           blatch_sel,
    output logic [1:0]           reg_sel
);

    useq_pkg::ctrl_t ctl;

    useq_upc #(.SLOT_BITS(SLOT_BITS), .STEP_BITS(STEP_BITS)) u_upc (
        .clk       (clk),
        .rst       (rst),
        .load      (ctl.ir_wr),
        .load_slot (ir_data),
        .upc       (upc_addr)
    );

    useq_store #(.SLOT_BITS(SLOT_BITS), .STEP_BITS(STEP_BITS)) u_store (
        .addr (upc_addr),
        .word (ctrl_word)
    );

    useq_decode u_dec (
        .word (ctrl_word[31:1]),
        .ctl  (ctl)
    );

    assign reg_wr     = ctl.reg_wr;
    assign reg_rd     = ctl.reg_rd;
    assign pc_wr_cond = ctl.pc_wr_cond;
    assign pc_rd      = ctl.pc_rd;
    assign cmp_latch  = ctl.cmp_latch;
    assign alu_a_wr   = ctl.alu_a_wr;
    assign alu_b_wr   = ctl.alu_b_wr;
    assign alu_o_rd   = ctl.alu_o_rd;
    assign alu_op     = ctl.alu_op;
    assign mdata_rd   = ctl.mdata_rd;
    assign mdata_wr   = ctl.mdata_wr;
    assign mem_en     = ctl.mem_en;
    assign mem_rw     = ctl.mem_rw;
    assign maddr_wr   = ctl.maddr_wr;
    assign maddr_inc  = ctl.maddr_inc;
    assign ir_wr      = ctl.ir_wr;
    assign imm_sel    = ctl.imm_sel;
    assign imm_en     = ctl.imm_en;
    assign blatch_en  = ctl.blatch_en;
    assign blatch_sel = ctl.blatch_sel;
    assign reg_sel    = ctl.reg_sel;

endmodule

// File: rtl/useq_checks.sv
module useq_checks #(
    parameter int SLOT_BITS = 4,
    parameter int STEP_BITS = 4,
    localparam int ADDR_W = SLOT_BITS + STEP_BITS
) (
    input logic                 clk,
    input logic                 rst,
    input logic [SLOT_BITS-1:0] ir_data,
    input logic [ADDR_W-1:0]    upc_addr,
    input logic [31:0]          ctrl_word,
    input logic                 ir_wr,
    input logic                 pc_rd,
    input logic                 maddr_wr
);

    assert_reset_entry_R1: assert property (@(posedge clk)
        rst |=> upc_addr == '0);

    assert_step_advance_R2: assert property (@(posedge clk) disable iff (rst)
        !ir_wr |=> (upc_addr[STEP_BITS-1:0] == STEP_BITS'($past(upc_addr[STEP_BITS-1:0]) + 1'b1))
                && (upc_addr[ADDR_W-1:STEP_BITS] == $past(upc_addr[ADDR_W-1:STEP_BITS])));

    assert_slot_load_R3: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> upc_addr == {$past(ir_data), {STEP_BITS{1'b0}}});

    assert_fetch_start_R5: assert property (@(posedge clk) disable iff (rst)
        (upc_addr == '0) |-> (pc_rd && maddr_wr && !ir_wr));

    always @(negedge clk) begin
        if (!rst)
            assert_spare_zero_R4: assert (ctrl_word[0] == 1'b0);
    end

endmodule

bind useq_top useq_checks #(.SLOT_BITS(SLOT_BITS), .STEP_BITS(STEP_BITS)) u_checks (
    .clk       (clk),
    .rst       (rst),
    .ir_data   (ir_data),
    .upc_addr  (upc_addr),
    .ctrl_word (ctrl_word),
    .ir_wr     (ir_wr),
    .pc_rd     (pc_rd),
    .maddr_wr  (maddr_wr)
);

// File: tb/useq_top_test.sv
module useq_top_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  ir_data;
    logic [7:0]  upc_addr;
    logic [31:0] ctrl_word;
    logic        reg_wr, reg_rd, pc_rd, cmp_latch, alu_a_wr, alu_b_wr, alu_o_rd;
    logic [2:0]  pc_wr_cond, imm_sel, blatch_sel;
    logic [3:0]  alu_op;
    logic        mdata_rd, mdata_wr, mem_en, mem_rw, maddr_wr, maddr_inc, ir_wr;
    logic        imm_en, blatch_en;
    logic [1:0]  reg_sel;

    int total = 0;
    int bad = 0;
    int m_op = 0;
    int m_st = 0;

    always #5 clk = ~clk;

    useq_top uut (
        .clk(clk), .rst(rst), .ir_data(ir_data), .upc_addr(upc_addr), .ctrl_word(ctrl_word),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .pc_wr_cond(pc_wr_cond), .pc_rd(pc_rd),
        .cmp_latch(cmp_latch), .alu_a_wr(alu_a_wr), .alu_b_wr(alu_b_wr), .alu_o_rd(alu_o_rd),
        .alu_op(alu_op), .mdata_rd(mdata_rd), .mdata_wr(mdata_wr), .mem_en(mem_en),
        .mem_rw(mem_rw), .maddr_wr(maddr_wr), .maddr_inc(maddr_inc), .ir_wr(ir_wr),
        .imm_sel(imm_sel), .imm_en(imm_en), .blatch_en(blatch_en), .blatch_sel(blatch_sel),
        .reg_sel(reg_sel)
    );

    function automatic logic [31:0] b(int p);
        return 32'd1 << p;
    endfunction

    function automatic logic [31:0] tail(int i);
        return (i == 0) ? (b(6) | b(8)) : (b(10) | b(21) | (32'd1 << 3));
    endfunction

    // Expected store contents from R5..R9
    function automatic logic [31:0] ew(int s, int t);
        logic [31:0] w;
        w = 32'd0;
        if (s == 0) begin
            if (t == 0) w = b(6) | b(19);
            else if (t <= 4) begin
                w = b(17) | b(18) | b(26) | (32'(4 - t) << 27);
                if (t < 4) w = w | b(20);
            end else if (t == 5) w = b(15) | b(21);
        end else if (s == 1) begin
            if (t == 0) w = b(25) | b(1) | (32'd3 << 22) | (32'd2 << 30);
            else if (t <= 2) w = tail(t - 1);
        end else if (s == 2) begin
            if (t == 0) w = b(2) | b(8);
            else if (t == 1) w = b(2) | b(9) | (32'd1 << 30);
            else if (t == 2) w = b(10) | b(1) | (32'd1 << 11) | (32'd2 << 30);
            else if (t <= 4) w = tail(t - 3);
        end
        return w;
    endfunction

    function automatic string word_tag(int s, int t);
        if (s == 0 && t <= 5) return "R5";
        if ((s == 1 && (t == 1 || t == 2)) || (s == 2 && (t == 3 || t == 4))) return "R6";
        if (s == 1 && t == 0) return "R7";
        if (s == 2 && t <= 2) return "R8";
        return "R9";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h (slot %0d step %0d)", tag, act, exp, m_op, m_st);
        end
    endtask

    task automatic check_all();
        logic [31:0] rebuilt;
        chk("R2 address", 32'(upc_addr), 32'(m_op * 16 + m_st));
        chk(word_tag(m_op, m_st), ctrl_word, ew(m_op, m_st));
        chk("R4 bit0", 32'(ctrl_word[0]), 32'd0);
        rebuilt = {reg_sel, blatch_sel, blatch_en, imm_en, imm_sel, ir_wr, maddr_inc, maddr_wr,
                   mem_rw, mem_en, mdata_wr, mdata_rd, alu_op, alu_o_rd, alu_b_wr, alu_a_wr,
                   cmp_latch, pc_rd, pc_wr_cond, reg_rd, reg_wr, 1'b0};
        chk("R10 decode", rebuilt, ew(m_op, m_st));
    endtask

    // Drive inputs at negedge, model the edge, check at next negedge
    task automatic tick(logic r, int d);
        logic [31:0] cur;
        rst = r;
        ir_data = 4'(d);
        cur = ew(m_op, m_st);
        @(posedge clk);
        if (r) begin
            m_op = 0;
            m_st = 0;
        end else if (cur[21]) begin
            m_op = d % 16;
            m_st = 0;
        end else begin
            m_st = (m_st + 1) % 16;
        end
        @(negedge clk);
        check_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int stuck;
        void'($urandom(32'd4242));
        rst = 1'b1;
        ir_data = 4'd0;
        @(negedge clk);
        tick(1'b1, 5);
        chk("R1 reset address", 32'(upc_addr), 32'd0);
        // fetch, then load slot 1 (R3)
        for (int i = 0; i < 5; i++) tick(1'b0, 7);
        tick(1'b0, 1);
        chk("R3 load slot1", 32'(upc_addr), 32'h10);
        tick(1'b0, 9);
        tick(1'b0, 9);
        tick(1'b0, 2);
        chk("R3 load slot2", 32'(upc_addr), 32'h20);
        for (int i = 0; i < 4; i++) tick(1'b0, 3);
        tick(1'b0, 0);
        chk("R3 return to fetch", 32'(upc_addr), 32'h00);
        // unprogrammed slot: wrap (R2) and zero words (R9)
        for (int i = 0; i < 5; i++) tick(1'b0, 0);
        tick(1'b0, 9);
        for (int i = 0; i < 18; i++) tick(1'b0, 0);
        chk("R2 wrap in slot9", 32'(upc_addr), 32'h92);
        tick(1'b1, 0);
        chk("R1 mid-slot reset", 32'(upc_addr), 32'd0);
        // random phase
        stuck = 0;
        for (int i = 0; i < 4000; i++) begin
            logic r;
            int d;
            d = ($urandom % 4 == 0) ? int'($urandom % 16) : int'($urandom % 3);
            stuck = (m_op > 2) ? stuck + 1 : 0;
            r = ($urandom % 64 == 0) || (stuck > 20);
            tick(r, d);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule